// File: doc/BRIEF.md
# Three-Lane Block FIR Filter with Shared Sub-Filters

This block filters a sample stream that arrives three samples at a time. Each clock with the valid strobe high carries three consecutive samples. The block returns the three matching filter outputs one clock later. The filter has a fixed set of NTAPS signed coefficients, given as a parameter.

Both the coefficients and the input stream are split by index modulo 3 into three phases. The filter does not build all nine phase-by-phase products. It uses six short direct-form sub-filters of NTAPS/3 taps each:
- three work on single phases;
- three work on sums of phases, with precomputed summed coefficients.

A small network of pre-adders feeds the sub-filters. A post-adder network combines their outputs and holds two block-delayed terms. Every output is full precision.

The block is meant for a datapath that has to run at one third of the sample rate. Cycles with the valid strobe low are gaps in the stream. They have no effect on the results.

Top module: `tri_fir`

## Requirements
- R1: Lane j of `inSamples` (bits [j*DW +: DW], signed) is stream sample 3k+j of block k. Lane j of `outSamples` (bits [j*OW +: OW], signed) is output 3k+j.
- R2: Each output equals the serial convolution y[n] = sum over i of h[i]·x[n−i], computed exactly, for every input pattern. Samples before the stream start count as zero.
- R3: `outValid` is high in the clock cycle after each cycle in which `inValid` is high, and it is low in every other cycle.
- R4: A cycle with `inValid` low changes no filter state. The outputs hold their values, and later results match a stream with the gap removed.
- R5: While `rstN` is low, `outValid` and all output lanes read zero. All sample history is cleared, so the next block after reset sees zeros as earlier samples.
- R6: Terms that cross a block boundary (phase 2 reaching lanes 0 and 1 of the next block) are applied exactly one valid block later.
- R7: Full-scale inputs of either sign give exact outputs with no wrap. OW = DW + CW + clog2(NTAPS).
- R8: Coefficient i occupies bits [i*CW +: CW] of `COEFS`. An impulse in stream position p gives h[n−p] at output n.
- R9: NTAPS is a multiple of 3 and at least 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block-rate clock |
| rstN | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | High when `inSamples` carries a block |
| inSamples | input | 3*DW | Three signed samples, lane 0 oldest |
| outValid | output | 1 | High when `outSamples` holds a new block |
| outSamples | output | 3*OW | Three signed full-precision outputs |

## Verification
The hardest case to reach from the ports is a term that crosses a block boundary and must survive gaps in the stream. The product of phase 2, and the difference of the sum of phases 1 and 2 minus phase 1, are both delayed by one block. The stimulus places single impulses in each lane in turn and follows them with idle cycles and zero blocks, which exposes those delayed paths one at a time. Random traffic with random gaps then checks the whole response against a serial convolution. Full-scale blocks of one sign, and of alternating signs, drive the widest intermediate sums.

// File: rtl/tri_fir_pkg.sv
package tri_fir_pkg;
  localparam int LANES = 3;
  localparam int SUBS  = 6;

  typedef struct packed {
    logic advance;   // shift sample history and delay registers
    logic capture;   // load output register
  } fir_strobe_t;

  // phase selection mask of sub-filter g: bit j set means phase j is summed
  function automatic logic [2:0] phaseMask(input int g);
    case (g)
      0:       return 3'b001;
      1:       return 3'b010;
      2:       return 3'b100;
      3:       return 3'b011;
      4:       return 3'b110;
      default: return 3'b111;
    endcase
  endfunction
endpackage

// File: rtl/tri_fir_sub.sv
module tri_fir_sub #(
  parameter int NTAPS = 9,
  parameter int CW    = 8,
  parameter int PW    = 14,
  parameter int AW    = 30,
  parameter logic [2:0] MASK = 3'b001,
  parameter logic [NTAPS*CW-1:0] COEFS = '0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 advance,
  input  logic signed [PW-1:0] sampleIn,
  output logic signed [AW-1:0] accOut
);
  localparam int M  = NTAPS / 3;
  localparam int KW = CW + 2;

  // summed coefficient of tap m, one bit of growth per addition
  function automatic logic signed [KW-1:0] coefAt(input int m);
    logic signed [KW-1:0] s;
    logic signed [CW-1:0] c;
    s = '0;
    for (int j = 0; j < 3; j++) begin
      if (MASK[j]) begin
        c = COEFS[(3*m+j)*CW +: CW];
        s = s + KW'(c);
      end
    end
    return s;
  endfunction

  logic signed [PW-1:0] histReg [M-1];
  logic signed [PW-1:0] tapVal  [M];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int m = 0; m < M-1; m++) histReg[m] <= '0;
    end else if (advance) begin
      histReg[0] <= sampleIn;
      for (int m = 1; m < M-1; m++) histReg[m] <= histReg[m-1];
    end
  end

  always_comb begin
    tapVal[0] = sampleIn;
    for (int m = 1; m < M; m++) tapVal[m] = histReg[m-1];
  end

  always_comb begin
    accOut = '0;
    for (int m = 0; m < M; m++) begin
      accOut = accOut + AW'(tapVal[m]) * AW'(coefAt(m));
    end
  end

  // R4: history moves only on a valid block
  a_r4_hist_hold: assert property (@(posedge clk) disable iff (!rstN)
    !advance |=> $stable(histReg[0]));
endmodule

// File: rtl/tri_fir_dp.sv
module tri_fir_dp
  import tri_fir_pkg::*;
#(
  parameter int NTAPS = 9,
  parameter int CW    = 8,
  parameter int DW    = 12,
  parameter int OW    = 24,
  parameter logic [NTAPS*CW-1:0] COEFS = '0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  fir_strobe_t           strobe,
  input  logic [LANES*DW-1:0]   inSamples,
  output logic [LANES*OW-1:0]   outSamples
);
  localparam int M  = NTAPS / 3;
  localparam int PW = DW + 2;
  localparam int AW = PW + CW + 2 + $clog2(M) + 1;
  localparam int IW = AW + 3;

  logic signed [DW-1:0] xIn   [LANES];
  logic signed [PW-1:0] subIn [SUBS];
  logic signed [AW-1:0] prod  [SUBS];

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    assign xIn[j] = inSamples[j*DW +: DW];
  end

  // three pre-adders
  logic signed [PW-1:0] sum01, sum12, sum012;
  assign sum01  = PW'(xIn[0]) + PW'(xIn[1]);
  assign sum12  = PW'(xIn[1]) + PW'(xIn[2]);
  assign sum012 = sum01 + PW'(xIn[2]);

  assign subIn[0] = PW'(xIn[0]);
  assign subIn[1] = PW'(xIn[1]);
  assign subIn[2] = PW'(xIn[2]);
  assign subIn[3] = sum01;
  assign subIn[4] = sum12;
  assign subIn[5] = sum012;

  for (genvar g = 0; g < SUBS; g++) begin : g_sub
    tri_fir_sub #(
      .NTAPS(NTAPS), .CW(CW), .PW(PW), .AW(AW),
      .MASK(phaseMask(g)), .COEFS(COEFS)
    ) sub_i (
      .clk(clk), .rstN(rstN), .advance(strobe.advance),
      .sampleIn(subIn[g]), .accOut(prod[g])
    );
  end

  // seven post-adders plus two block delays
  logic signed [IW-1:0] p0, p1, p2, p3, p4, p5;
  logic signed [IW-1:0] t01, t12, t0d, yNext0, yNext1, y2Part, yNext2;
  logic signed [IW-1:0] dlyP2, dlyT12;

  assign p0 = IW'(prod[0]);
  assign p1 = IW'(prod[1]);
  assign p2 = IW'(prod[2]);
  assign p3 = IW'(prod[3]);
  assign p4 = IW'(prod[4]);
  assign p5 = IW'(prod[5]);

  assign t01    = p3 - p1;
  assign t12    = p4 - p1;
  assign t0d    = p0 - dlyP2;
  assign yNext1 = t01 - t0d;
  assign yNext0 = t0d + dlyT12;
  assign y2Part = p5 - t01;
  assign yNext2 = y2Part - t12;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dlyP2  <= '0;
      dlyT12 <= '0;
    end else if (strobe.advance) begin
      dlyP2  <= p2;
      dlyT12 <= t12;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outSamples <= '0;
    end else if (strobe.capture) begin
      outSamples[0*OW +: OW] <= yNext0[OW-1:0];
      outSamples[1*OW +: OW] <= yNext1[OW-1:0];
      outSamples[2*OW +: OW] <= yNext2[OW-1:0];
    end
  end

  // R7: the combined results fit the output width (upper bits are sign copies)
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |->
      ((yNext0[IW-1:OW-1] == '0) || (yNext0[IW-1:OW-1] == '1)) &&
      ((yNext1[IW-1:OW-1] == '0) || (yNext1[IW-1:OW-1] == '1)) &&
      ((yNext2[IW-1:OW-1] == '0) || (yNext2[IW-1:OW-1] == '1)));

  // R4: outputs and block delays hold across gaps
  a_r4_out_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> $stable(outSamples));
  a_r6_delay_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.advance |=> ($stable(dlyP2) && $stable(dlyT12)));
endmodule

// File: rtl/tri_fir_ctrl.sv
module tri_fir_ctrl
  import tri_fir_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output fir_strobe_t strobe,
  output logic        outValid
);
  assign strobe.advance = inValid;
  assign strobe.capture = inValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  // R3: one-cycle valid pipeline
  a_r3_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  a_r3_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
endmodule

// File: rtl/tri_fir.sv
module tri_fir
  import tri_fir_pkg::*;
#(
  parameter int NTAPS = 9,
  parameter int CW    = 8,
  parameter int DW    = 12,
  parameter int OW    = DW + CW + $clog2(NTAPS),
  parameter logic [NTAPS*CW-1:0] COEFS = {
    -8'sd77, 8'sd27, -8'sd3, 8'sd64, 8'h80, 8'sd99, 8'sd5, -8'sd42, 8'sd17}
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic [3*DW-1:0]     inSamples,
  output logic                outValid,
  output logic [3*OW-1:0]     outSamples
);
  // R9: NTAPS must be a multiple of 3 and at least 6
  fir_strobe_t strobe;

  tri_fir_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .strobe(strobe), .outValid(outValid)
  );

  tri_fir_dp #(
    .NTAPS(NTAPS), .CW(CW), .DW(DW), .OW(OW), .COEFS(COEFS)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .inSamples(inSamples), .outSamples(outSamples)
  );
endmodule

// File: tb/tri_fir_tb_top.sv
`timescale 1ns/1ps
module tri_fir_tb_top;
  localparam int NTAPS = 9;
  localparam int CW    = 8;
  localparam int DW    = 12;
  localparam int OW    = DW + CW + $clog2(NTAPS);
  localparam logic [NTAPS*CW-1:0] COEFS = {
    -8'sd77, 8'sd27, -8'sd3, 8'sd64, 8'h80, 8'sd99, 8'sd5, -8'sd42, 8'sd17};

  logic clk = 0;
  logic rstN = 0;
  logic inValid = 0;
  logic [3*DW-1:0] inSamples = '0;
  logic outValid;
  logic [3*OW-1:0] outSamples;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  int xs [0:8191];
  int nx = 0;

  always #10 clk = ~clk;

  tri_fir #(.NTAPS(NTAPS), .CW(CW), .DW(DW), .OW(OW), .COEFS(COEFS)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSamples(inSamples),
    .outValid(outValid), .outSamples(outSamples)
  );

  function automatic longint coefOf(input int i);
    logic signed [CW-1:0] c;
    c = COEFS[i*CW +: CW];
    return longint'(c);
  endfunction

  function automatic longint refY(input int n);
    longint acc = 0;
    for (int i = 0; i < NTAPS; i++)
      if (n - i >= 0) acc += coefOf(i) * longint'(xs[n-i]);
    return acc;
  endfunction

  function automatic longint lane(input int j);
    logic signed [OW-1:0] v;
    v = outSamples[j*OW +: OW];
    return longint'(v);
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // caller sits at a negedge; sends one block and checks its outputs
  task automatic sendBlock(input int a, input int b, input int c, input string req);
    int base;
    inValid = 1;
    inSamples = {DW'(c), DW'(b), DW'(a)};
    xs[nx] = a; xs[nx+1] = b; xs[nx+2] = c;
    base = nx;
    nx += 3;
    @(posedge clk); @(negedge clk);
    check(outValid == 1'b1, "R3", longint'(outValid), 1);
    for (int j = 0; j < 3; j++)
      check(lane(j) == refY(base + j), req, lane(j), refY(base + j));
  endtask

  task automatic idleCycle();
    longint held [3];
    for (int j = 0; j < 3; j++) held[j] = lane(j);
    inValid = 0;
    inSamples = {$urandom, $urandom};
    @(posedge clk); @(negedge clk);
    check(outValid == 1'b0, "R3", longint'(outValid), 0);
    for (int j = 0; j < 3; j++) check(lane(j) == held[j], "R4", lane(j), held[j]);
  endtask

  function automatic int rndSample();
    logic signed [DW-1:0] v;
    v = DW'($urandom);
    return int'(v);
  endfunction

  task automatic doReset();
    inValid = 0;
    rstN = 0;
    @(posedge clk); @(negedge clk);
    check(outValid == 1'b0, "R5", longint'(outValid), 0);
    for (int j = 0; j < 3; j++) check(lane(j) == 0, "R5", lane(j), 0);
    rstN = 1;
    nx = 0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    doReset();
    // R8/R1: impulse in each lane, then zero blocks to expose the whole response
    for (int p = 0; p < 3; p++) begin
      sendBlock(p == 0, p == 1, p == 2, "R8");
      idleCycle();
      for (int k = 0; k < 4; k++) begin
        sendBlock(0, 0, 0, "R6");
        idleCycle();
      end
    end
    // R6: phase-2 impulse with a long gap before the next block
    sendBlock(0, 0, 1000, "R6");
    for (int k = 0; k < 5; k++) idleCycle();
    sendBlock(0, 0, 0, "R6");
    sendBlock(-7, 0, 0, "R6");
    // R2/R4: random stream with random gaps
    for (int k = 0; k < 400; k++) begin
      sendBlock(rndSample(), rndSample(), rndSample(), "R2");
      if ($urandom_range(3) == 0) idleCycle();
    end
    // R7: full scale of one sign, then alternating signs
    for (int k = 0; k < 5; k++) sendBlock(-2048, -2048, -2048, "R7");
    for (int k = 0; k < 5; k++) sendBlock(2047, 2047, 2047, "R7");
    for (int k = 0; k < 6; k++) sendBlock(2047, -2048, 2047, "R7");
    for (int k = 0; k < 6; k++) sendBlock(-2048, 2047, -2048, "R7");
    // R5: reset mid-stream clears history
    doReset();
    sendBlock(5, -3, 9, "R5");
    sendBlock(0, 0, 0, "R5");
    for (int k = 0; k < 50; k++) sendBlock(rndSample(), rndSample(), rndSample(), "R2");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule